// File: doc/BRIEF.md
# ASID-Tagged Translation Cache

This block is a small, fully associative cache of virtual-to-physical page translations for a three-level, 39-bit virtual memory scheme. Each entry carries a 16-bit address-space identifier, a virtual page number, a page-size code (4 KiB, 2 MiB or 1 GiB), a physical page number and eight PTE flag bits. A lookup presents a virtual address and an identifier. One cycle later the block reports hit or miss, the translated physical address and the stored flags.

An external page-table walker fills the cache through an insert port. Free slots are used before anything is evicted. When the cache is full, the entry whose age stamp is smallest is replaced. Age stamps come from one global counter that advances on every counted hit and on every new allocation. A fence-style flush port takes an address operand and an identifier operand. Whether each operand is zero or non-zero selects one of four invalidation scopes.

Top module: `asid_tlb`

## Requirements
- R1: While `rst` is high on a clock edge, every entry becomes invalid, the global stamp counter returns to zero and `rsp_valid` is low afterwards. Lookups made after reset miss.
- R2: `rsp_valid` is `lk_valid` delayed by one clock. `rsp_hit` is never high while `rsp_valid` is low. On a miss, `rsp_paddr` and `rsp_flags` are zero.
- R3: A lookup hits an entry only when all of the following hold: the entry is valid, its identifier equals `lk_asid`, and its page number equals bits 38:12 of `lk_vaddr` above the entry's page-size boundary. Size code 0 compares bits 38:12, code 1 compares bits 38:21, and codes 2 and 3 compare bits 38:30.
- R4: On a hit, `rsp_paddr` is the stored physical page number shifted left by 12, with the bits below the page boundary cleared, OR-ed with the bits of `lk_vaddr` below that boundary (12, 21 or 30 bits).
- R5: On a hit, `rsp_flags` returns the flag byte most recently written to that entry.
- R6: An insert that matches no valid entry is placed in the lowest-numbered invalid slot, if there is one, and evicts nothing.
- R7: An insert that matches no valid entry while all slots are valid replaces the entry with the smallest stamp. A non-hidden lookup hit gives that entry the current counter value, and a new entry also receives a fresh value.
- R8: A lookup with `lk_hidden` high returns the normal result but leaves all stamps and the counter unchanged.
- R9: An insert whose address and identifier already hit a valid entry overwrites only that entry's flags. No slot is allocated, and the physical page number is kept.
- R10: A flush with `fl_vaddr` = 0 and `fl_asid[15:0]` = 0 invalidates every entry.
- R11: A flush with `fl_vaddr` = 0 and a non-zero `fl_asid[15:0]` invalidates exactly the entries holding that identifier.
- R12: A flush with a non-zero `fl_vaddr` and `fl_asid[15:0]` = 0 invalidates every entry whose page covers `fl_vaddr`, whatever its identifier.
- R13: A flush with both operands non-zero invalidates only the entries that cover `fl_vaddr` and hold identifier `fl_asid[15:0]`. Bits 31:16 of `fl_asid` are ignored in every flush mode.
- R14: When `fl_valid` and `ins_valid` are high in the same cycle, the flush takes effect and the insert is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_hidden | input | 1 | Lookup that does not refresh the stamp |
| lk_vaddr | input | 39 | Lookup virtual address |
| lk_asid | input | 16 | Lookup address-space identifier |
| rsp_valid | output | 1 | Lookup response valid (one cycle after request) |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 56 | Translated physical address |
| rsp_flags | output | 8 | Stored PTE flags of the hit entry |
| ins_valid | input | 1 | Insert request from the walker |
| ins_vaddr | input | 39 | Virtual address of the new translation |
| ins_asid | input | 16 | Identifier of the new translation |
| ins_size | input | 2 | Page size code: 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| ins_ppn | input | 44 | Physical page number |
| ins_flags | input | 8 | PTE flag bits |
| fl_valid | input | 1 | Flush command |
| fl_vaddr | input | 39 | Flush address operand (zero selects all addresses) |
| fl_asid | input | 32 | Flush identifier operand; low 16 bits used, zero selects all identifiers |

## Verification
The bench builds the cache with `NUM_ENTRIES` = 4 instead of the default 16. With four slots, a few inserts fill the array, so eviction, hit-driven stamp refresh and refill of slots freed by a flush all happen often, both in the directed cases and under random traffic. Random addresses are drawn from a small pool of page numbers and identifiers, with page sizes mixed. This makes superpage coverage, identifier mismatches, insert merges and all four flush scopes collide on the same entries.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int PAGE_SHIFT = 12;
    localparam int LVL_BITS   = 9;
    localparam int VA_W       = 39;
    localparam int PA_W       = 56;
    localparam int ASID_W     = 16;
    localparam int FLAG_W     = 8;
    localparam int SEQ_W      = 32;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;
    localparam int PPN_W      = PA_W - PAGE_SHIFT;

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_2M  = 2'd1,
        PG_1G  = 2'd2,
        PG_1GX = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic                valid;
        logic [ASID_W-1:0]   asid;
        logic [VPN_W-1:0]    vpn;
        pg_size_e            size;
        logic [PPN_W-1:0]    ppn;
        logic [FLAG_W-1:0]   flags;
        logic [SEQ_W-1:0]    stamp;
    } tlb_entry_t;

    // Number of page-number bits that sit below the page boundary.
    function automatic int low_bits(pg_size_e s);
        int lvl;
        lvl = (s == PG_1GX) ? 2 : int'(s);
        return lvl * LVL_BITS;
    endfunction

    function automatic logic [VPN_W-1:0] vpn_mask(pg_size_e s);
        logic [VPN_W-1:0] m;
        m = '1;
        return m << low_bits(s);
    endfunction

    function automatic logic [PPN_W-1:0] ppn_mask(pg_size_e s);
        logic [PPN_W-1:0] m;
        m = '1;
        return m << low_bits(s);
    endfunction

    function automatic logic [VA_W-1:0] va_offset_mask(pg_size_e s);
        return {~vpn_mask(s), {PAGE_SHIFT{1'b1}}};
    endfunction

    // Search key: identifier placed above the page number.
    function automatic logic [ASID_W+VPN_W-1:0] make_key(logic [ASID_W-1:0] asid,
                                                         logic [VPN_W-1:0]  vpn);
        return {asid, vpn};
    endfunction

endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match
    import tlb_pkg::*;
(
    input  tlb_entry_t          ent,
    input  logic [VA_W-1:0]     probe_vaddr,
    input  logic [ASID_W-1:0]   probe_asid,
    input  logic                use_vaddr,
    input  logic                use_asid,
    output logic                hit
);
    logic [VPN_W-1:0]           mask;
    logic [ASID_W+VPN_W-1:0]    ent_key;
    logic [ASID_W+VPN_W-1:0]    probe_key;
    logic                       vpn_ok;
    logic                       asid_ok;

    always_comb begin
        mask      = vpn_mask(ent.size);
        ent_key   = make_key(ent.asid, ent.vpn & mask);
        probe_key = make_key(probe_asid, probe_vaddr[VA_W-1:PAGE_SHIFT] & mask);
        vpn_ok    = !use_vaddr || (ent_key[VPN_W-1:0] == probe_key[VPN_W-1:0]);
        asid_ok   = !use_asid  || (ent_key[ASID_W+VPN_W-1:VPN_W] ==
                                   probe_key[ASID_W+VPN_W-1:VPN_W]);
        hit       = ent.valid && vpn_ok && asid_ok;
    end
endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel
    import tlb_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             valid,
    input  logic [N-1:0][SEQ_W-1:0]  stamps,
    output logic [IDX_W-1:0]         victim
);
    logic              have_free;
    logic [IDX_W-1:0]  free_idx;
    logic [IDX_W-1:0]  old_idx;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
        end
        old_idx = '0;
        for (int i = 1; i < N; i++) begin
            if (stamps[i] < stamps[old_idx]) begin
                old_idx = IDX_W'(i);
            end
        end
        victim = have_free ? free_idx : old_idx;
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int FLUSH_OP_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lk_valid,
    input  logic                 lk_hidden,
    input  logic [VA_W-1:0]      lk_vaddr,
    input  logic [ASID_W-1:0]    lk_asid,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [PA_W-1:0]      rsp_paddr,
    output logic [FLAG_W-1:0]    rsp_flags,
    input  logic                 ins_valid,
    input  logic [VA_W-1:0]      ins_vaddr,
    input  logic [ASID_W-1:0]    ins_asid,
    input  logic [1:0]           ins_size,
    input  logic [PPN_W-1:0]     ins_ppn,
    input  logic [FLAG_W-1:0]    ins_flags,
    input  logic                 fl_valid,
    input  logic [VA_W-1:0]      fl_vaddr,
    input  logic [FLUSH_OP_W-1:0] fl_asid
);
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    tlb_entry_t                        ent_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0]            ent_valid;
    logic [NUM_ENTRIES-1:0][SEQ_W-1:0] ent_stamp;
    logic [NUM_ENTRIES-1:0]            lk_hit_vec;
    logic [NUM_ENTRIES-1:0]            ins_hit_vec;
    logic [NUM_ENTRIES-1:0]            fl_hit_vec;
    logic [SEQ_W-1:0]                  seq_q;

    logic [ASID_W-1:0]  fl_asid_lo;
    logic               fl_by_addr;
    logic               fl_by_asid;
    logic [IDX_W-1:0]   lk_idx;
    logic [IDX_W-1:0]   ins_idx;
    logic [IDX_W-1:0]   vic_idx;
    logic               lk_any;
    logic               ins_any;
    logic               lk_refresh;
    logic               ins_go;
    logic               do_alloc;
    logic               do_merge;
    tlb_entry_t         lk_ent;
    tlb_entry_t         new_ent;
    logic [PA_W-1:0]    lk_paddr;

    assign fl_asid_lo = fl_asid[ASID_W-1:0];
    assign fl_by_addr = (fl_vaddr != '0);
    assign fl_by_asid = (fl_asid_lo != '0);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        assign ent_valid[g] = ent_q[g].valid;
        assign ent_stamp[g] = ent_q[g].stamp;

        tlb_cam_match u_lk_cmp (
            .ent(ent_q[g]), .probe_vaddr(lk_vaddr), .probe_asid(lk_asid),
            .use_vaddr(1'b1), .use_asid(1'b1), .hit(lk_hit_vec[g])
        );
        tlb_cam_match u_ins_cmp (
            .ent(ent_q[g]), .probe_vaddr(ins_vaddr), .probe_asid(ins_asid),
            .use_vaddr(1'b1), .use_asid(1'b1), .hit(ins_hit_vec[g])
        );
        tlb_cam_match u_fl_cmp (
            .ent(ent_q[g]), .probe_vaddr(fl_vaddr), .probe_asid(fl_asid_lo),
            .use_vaddr(fl_by_addr), .use_asid(fl_by_asid), .hit(fl_hit_vec[g])
        );
    end

    tlb_victim_sel #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_victim (
        .valid(ent_valid), .stamps(ent_stamp), .victim(vic_idx)
    );

    // Lowest-index hit wins for both probe ports.
    always_comb begin
        lk_idx  = '0;
        ins_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (lk_hit_vec[i])  lk_idx  = IDX_W'(i);
            if (ins_hit_vec[i]) ins_idx = IDX_W'(i);
        end
    end

    assign lk_any     = |lk_hit_vec;
    assign ins_any    = |ins_hit_vec;
    assign lk_refresh = lk_valid && !lk_hidden && lk_any;
    assign ins_go     = ins_valid && !fl_valid;
    assign do_alloc   = ins_go && !ins_any;
    assign do_merge   = ins_go && ins_any;

    always_comb begin
        lk_ent   = ent_q[lk_idx];
        lk_paddr = {lk_ent.ppn & ppn_mask(lk_ent.size), {PAGE_SHIFT{1'b0}}}
                 | PA_W'(lk_vaddr & va_offset_mask(lk_ent.size));

        new_ent.valid = 1'b1;
        new_ent.asid  = ins_asid;
        new_ent.vpn   = ins_vaddr[VA_W-1:PAGE_SHIFT];
        new_ent.size  = pg_size_e'(ins_size);
        new_ent.ppn   = ins_ppn;
        new_ent.flags = ins_flags;
        new_ent.stamp = seq_q + SEQ_W'(lk_refresh);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_paddr <= '0;
            rsp_flags <= '0;
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                ent_q[i].valid <= 1'b0;
            end
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_any;
            rsp_paddr <= (lk_valid && lk_any) ? lk_paddr : '0;
            rsp_flags <= (lk_valid && lk_any) ? lk_ent.flags : '0;

            if (lk_refresh) begin
                ent_q[lk_idx].stamp <= seq_q;
            end
            if (do_merge) begin
                ent_q[ins_idx].flags <= ins_flags;
            end
            if (do_alloc) begin
                ent_q[vic_idx] <= new_ent;
            end
            if (fl_valid) begin
                for (int i = 0; i < NUM_ENTRIES; i++) begin
                    if (fl_hit_vec[i]) ent_q[i].valid <= 1'b0;
                end
            end
            seq_q <= seq_q + SEQ_W'(lk_refresh) + SEQ_W'(do_alloc);
        end
    end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
    import tlb_pkg::*;
#(
    parameter int N    = 16,
    parameter int FL_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic              lk_hidden,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              ins_valid,
    input logic              fl_valid,
    input logic [VA_W-1:0]   fl_vaddr,
    input logic [FL_W-1:0]   fl_asid,
    input logic [N-1:0]      ent_valid,
    input logic [SEQ_W-1:0]  seq_q
);
    // R2: response strobe is the request strobe one cycle later
    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);
    a_r2_rsp_idle: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);
    a_r2_hit_qualified: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    // R8: hidden lookup with no insert leaves the stamp counter alone
    a_r8_hidden_no_stamp: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_hidden && !ins_valid) |=> $stable(seq_q));

    // R10: both operands zero empties the array
    a_r10_flush_all: assert property (@(posedge clk) disable iff (rst)
        (fl_valid && fl_vaddr == '0 && fl_asid[ASID_W-1:0] == '0) |=> (ent_valid == '0));

    // R14: a flush cycle never adds a valid entry, even with an insert pending
    a_r14_flush_blocks_insert: assert property (@(posedge clk) disable iff (rst)
        fl_valid |=> ($countones(ent_valid) <= $past($countones(ent_valid))));
endmodule

bind asid_tlb tlb_checker #(.N(NUM_ENTRIES), .FL_W(FLUSH_OP_W)) u_tlb_checker (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_hidden(lk_hidden),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .ins_valid(ins_valid),
    .fl_valid(fl_valid), .fl_vaddr(fl_vaddr), .fl_asid(fl_asid),
    .ent_valid(ent_valid), .seq_q(seq_q)
);

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
    import tlb_pkg::*;

    localparam int TB_N = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                lk_valid = 1'b0, lk_hidden = 1'b0;
    logic [VA_W-1:0]     lk_vaddr = '0;
    logic [ASID_W-1:0]   lk_asid = '0;
    logic                rsp_valid, rsp_hit;
    logic [PA_W-1:0]     rsp_paddr;
    logic [FLAG_W-1:0]   rsp_flags;
    logic                ins_valid = 1'b0;
    logic [VA_W-1:0]     ins_vaddr = '0;
    logic [ASID_W-1:0]   ins_asid = '0;
    logic [1:0]          ins_size = '0;
    logic [PPN_W-1:0]    ins_ppn = '0;
    logic [FLAG_W-1:0]   ins_flags = '0;
    logic                fl_valid = 1'b0;
    logic [VA_W-1:0]     fl_vaddr = '0;
    logic [31:0]         fl_asid = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    asid_tlb #(.NUM_ENTRIES(TB_N), .FLUSH_OP_W(32)) dut (.*);

    // Bench-side model of the cache contents
    logic              m_v   [TB_N];
    logic [VPN_W-1:0]  m_vpn [TB_N];
    logic [15:0]       m_as  [TB_N];
    logic [1:0]        m_sz  [TB_N];
    logic [PPN_W-1:0]  m_ppn [TB_N];
    logic [7:0]        m_fl  [TB_N];
    int unsigned       m_st  [TB_N];
    int unsigned       m_seq;

    function automatic int shift_of(logic [1:0] sz);
        return ((sz == 2'd3) ? 2 : int'(sz)) * 9;
    endfunction

    function automatic bit covers(int i, logic [VA_W-1:0] va);
        logic [VPN_W-1:0] d;
        d = m_vpn[i] ^ va[VA_W-1:12];
        return (d >> shift_of(m_sz[i])) == '0;
    endfunction

    function automatic logic [63:0] model_pa(int i, logic [VA_W-1:0] va);
        int sh;
        logic [63:0] pg;
        sh = shift_of(m_sz[i]);
        pg = (64'(m_ppn[i]) >> sh) << sh;
        return (pg << 12) | (64'(va) & ((64'd1 << (12 + sh)) - 64'd1));
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One clock of stimulus; starts and ends just after a falling edge.
    task automatic cyc(input logic lv, input logic lh, input logic [VA_W-1:0] la,
                       input logic [15:0] las, input logic iv, input logic [VA_W-1:0] iva,
                       input logic [15:0] ias, input logic [1:0] isz,
                       input logic [PPN_W-1:0] ippn, input logic [7:0] ifl,
                       input logic fv, input logic [VA_W-1:0] fva, input logic [31:0] fas,
                       input string tag);
        int hi, mi, vic;
        bit exp_hit, lk_st, go, fhit[TB_N];
        logic [63:0] exp_pa;
        logic [7:0] exp_fl;
        hi = -1; mi = -1; vic = -1;
        for (int i = 0; i < TB_N; i++)
            if (hi < 0 && m_v[i] && m_as[i] == las && covers(i, la)) hi = i;
        exp_hit = lv && (hi >= 0);
        exp_pa  = exp_hit ? model_pa(hi, la) : 64'd0;
        exp_fl  = exp_hit ? m_fl[hi] : 8'd0;
        lk_st   = lv && !lh && (hi >= 0);
        go      = iv && !fv;
        for (int i = 0; i < TB_N; i++)
            if (mi < 0 && m_v[i] && m_as[i] == ias && covers(i, iva)) mi = i;
        for (int i = 0; i < TB_N; i++)
            if (vic < 0 && !m_v[i]) vic = i;
        if (vic < 0) begin
            vic = 0;
            for (int i = 1; i < TB_N; i++) if (m_st[i] < m_st[vic]) vic = i;
        end
        for (int i = 0; i < TB_N; i++)
            fhit[i] = fv && m_v[i] && (fva == '0 || covers(i, fva)) &&
                      (fas[15:0] == 16'd0 || m_as[i] == fas[15:0]);
        if (lk_st) m_st[hi] = m_seq;
        if (go && mi >= 0) m_fl[mi] = ifl;
        if (go && mi < 0) begin
            m_v[vic] = 1'b1; m_vpn[vic] = iva[VA_W-1:12]; m_as[vic] = ias;
            m_sz[vic] = isz; m_ppn[vic] = ippn; m_fl[vic] = ifl;
            m_st[vic] = m_seq + (lk_st ? 1 : 0);
        end
        for (int i = 0; i < TB_N; i++) if (fhit[i]) m_v[i] = 1'b0;
        m_seq = m_seq + (lk_st ? 1 : 0) + ((go && mi < 0) ? 1 : 0);

        lk_valid = lv; lk_hidden = lh; lk_vaddr = la; lk_asid = las;
        ins_valid = iv; ins_vaddr = iva; ins_asid = ias; ins_size = isz;
        ins_ppn = ippn; ins_flags = ifl;
        fl_valid = fv; fl_vaddr = fva; fl_asid = fas;
        @(posedge clk);
        #2;
        check(tag, "rsp_valid (R2)", 64'(rsp_valid), 64'(lv));
        if (lv) begin
            check(tag, "rsp_hit", 64'(rsp_hit), 64'(exp_hit));
            check(tag, "rsp_paddr", 64'(rsp_paddr), exp_pa);
            check(tag, "rsp_flags", 64'(rsp_flags), 64'(exp_fl));
        end
        lk_valid = 1'b0; ins_valid = 1'b0; fl_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic lookup(input logic [VA_W-1:0] va, input logic [15:0] as,
                          input logic hid, input string tag);
        cyc(1'b1, hid, va, as, 1'b0, '0, '0, 2'd0, '0, '0, 1'b0, '0, '0, tag);
    endtask

    task automatic insert(input logic [VA_W-1:0] va, input logic [15:0] as,
                          input logic [1:0] sz, input logic [PPN_W-1:0] ppn,
                          input logic [7:0] fl, input string tag);
        cyc(1'b0, 1'b0, '0, '0, 1'b1, va, as, sz, ppn, fl, 1'b0, '0, '0, tag);
    endtask

    task automatic flush(input logic [VA_W-1:0] va, input logic [31:0] as, input string tag);
        cyc(1'b0, 1'b0, '0, '0, 1'b0, '0, '0, 2'd0, '0, '0, 1'b1, va, as, tag);
    endtask

    function automatic logic [VA_W-1:0] rand_va();
        logic [VA_W-1:0] v;
        v[38:30] = 9'($urandom_range(1, 2));
        v[29:21] = 9'($urandom_range(0, 1) * 5);
        v[20:12] = 9'($urandom_range(0, 3));
        v[11:0]  = 12'($urandom);
        return v;
    endfunction

    localparam logic [VA_W-1:0] VA_A = 39'h00_1234_5678;
    localparam logic [VA_W-1:0] VA_B = 39'h04_0060_0000;
    localparam logic [VA_W-1:0] VA_C = 39'h40_0000_0000;
    localparam logic [VA_W-1:0] VA_D = 39'h08_0000_3000;
    localparam logic [VA_W-1:0] VA_E = 39'h10_0000_7000;

    initial begin
        void'($urandom(32'h0000_5eed));
        for (int i = 0; i < TB_N; i++) begin
            m_v[i] = 1'b0; m_st[i] = 0; m_vpn[i] = '0; m_as[i] = '0;
            m_sz[i] = '0; m_ppn[i] = '0; m_fl[i] = '0;
        end
        m_seq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        lookup(VA_A, 16'd1, 1'b0, "R1 miss after reset");

        insert(VA_A, 16'd1, 2'd0, 44'h0AB_CDEF, 8'hCF, "R6 first insert");
        lookup(VA_A ^ 39'h123, 16'd1, 1'b0, "R3 R4 R5 4K hit");
        lookup(VA_A, 16'd2, 1'b0, "R3 identifier mismatch");
        insert(VA_B, 16'd1, 2'd1, 44'h777_7FFF, 8'h5B, "R6 2M insert");
        lookup(VA_B | 39'h1F_F123, 16'd1, 1'b0, "R3 R4 2M hit");
        insert(VA_C, 16'd2, 2'd2, 44'h3_FFFF_FFFF, 8'h1F, "R6 1G insert");
        lookup(VA_C | 39'h2ABC_DEF1, 16'd2, 1'b0, "R3 R4 1G hit");
        insert(VA_A, 16'd1, 2'd0, 44'h111_1111, 8'h33, "R9 merge insert");
        lookup(VA_A, 16'd1, 1'b0, "R9 merged flags kept ppn");
        insert(VA_D, 16'd3, 2'd0, 44'h000_0042, 8'h0F, "R6 fill last slot");
        lookup(VA_A, 16'd1, 1'b0, "R7 refresh A");
        lookup(VA_B, 16'd1, 1'b1, "R8 hidden lookup B");
        insert(VA_E, 16'd1, 2'd0, 44'h000_0E0E, 8'h07, "R7 evict oldest");
        lookup(VA_B, 16'd1, 1'b1, "R7 R8 oldest evicted");
        lookup(VA_A, 16'd1, 1'b1, "R7 refreshed entry kept");
        flush(VA_A, 32'hBEEF_0001, "R13 flush addr and asid");
        lookup(VA_A, 16'd1, 1'b1, "R13 target gone");
        lookup(VA_D, 16'd3, 1'b1, "R13 other kept");
        insert(39'h20_0000_1000, 16'd4, 2'd0, 44'h0000_0099, 8'h01, "R6 reuse freed slot");
        lookup(VA_C, 16'd2, 1'b1, "R6 no eviction C");
        lookup(VA_E, 16'd1, 1'b1, "R6 no eviction E");
        flush('0, 32'h0000_0003, "R11 flush by asid");
        lookup(VA_D, 16'd3, 1'b1, "R11 asid entries gone");
        lookup(VA_C, 16'd2, 1'b1, "R11 other asid kept");
        insert(VA_E, 16'd2, 2'd0, 44'h0000_0ABC, 8'h11, "R12 same page other asid");
        flush(VA_E | 39'h5A5, 32'hFFFF_0000, "R12 flush by address");
        lookup(VA_E, 16'd1, 1'b1, "R12 asid1 gone");
        lookup(VA_E, 16'd2, 1'b1, "R12 asid2 gone");
        lookup(VA_C, 16'd2, 1'b1, "R12 unrelated kept");
        cyc(1'b0, 1'b0, '0, '0, 1'b1, VA_B, 16'd5, 2'd0, 44'h55, 8'h55,
            1'b1, '0, 32'h0000_0007, "R14 flush with insert");
        lookup(VA_B, 16'd5, 1'b1, "R14 insert dropped");
        flush('0, 32'hABCD_0000, "R10 flush all");
        lookup(VA_C, 16'd2, 1'b0, "R10 all gone");
        lookup(39'h20_0000_1000, 16'd4, 1'b0, "R10 all gone 2");

        for (int k = 0; k < 4000; k++) begin
            int op;
            op = int'($urandom_range(0, 15));
            cyc(op < 12, $urandom_range(0, 3) == 0, rand_va(), 16'($urandom_range(0, 3)),
                op >= 8 && op < 15, rand_va(), 16'($urandom_range(0, 3)),
                2'($urandom_range(0, 2)), 44'($urandom), 8'($urandom),
                op == 15 || (op == 11 && $urandom_range(0, 3) == 0),
                ($urandom_range(0, 1) == 0) ? '0 : rand_va(),
                {16'($urandom), 16'($urandom_range(0, 3))},
                "R3 R7 R9 R13 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule